// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts the direction of a conditional branch by combining two independent predictors and a per-branch arbiter. The first predictor looks only at the outcomes of the most recent branches in program order. That global history is used directly as the index into a table of 2-bit saturating counters. The second predictor works in two levels. The branch address selects a per-branch history word of recent outcomes of that one branch, and that word then indexes a table of 3-bit saturating counters. An address-indexed table of 2-bit arbiter counters records which of the two predictors has been right more often for each branch, and the block outputs that predictor's answer.

The lookup side is purely combinational. The fetch stage presents the low address bits of a branch and gets back four things: the final direction, which component was chosen, both component votes, and the two table indices that were used. The pipeline keeps these alongside the branch. When the branch resolves, it returns them on the update port together with the real outcome, and all state is trained in a single clock edge. An update does not affect a lookup made in the same cycle. It takes effect from the next cycle onward. Table sizes are parameters: the defaults give 1K-entry tables, the full-size arrangement uses a 12-bit global history with 4K entries, and a small configuration is used for exhaustive simulation.

Top module: `tourney_pred`

## Requirements
- R1: On synchronous active-high reset, the global history and every per-branch history become zero. Every 2-bit counter (global and arbiter) becomes 1 and every 3-bit counter becomes 3. As a result, every lookup after reset reports not-taken for both components and selects the local component.
- R2: `lk_glob_idx` equals the global history register. On each accepted update it shifts left by one, and `up_taken` enters bit 0, so bit 0 always holds the newest outcome.
- R3: The global counter at `up_glob_idx` increments on taken and decrements on not-taken, saturating at 0 and 3. `lk_glob_pred` is 1 when the counter at `lk_glob_idx` is 2 or more.
- R4: `lk_loc_idx` is the per-branch history entry selected by the low LHT_IDX_W bits of `lk_pc`. On an accepted update, the entry selected by `up_pc` shifts left and takes `up_taken` into bit 0.
- R5: The 3-bit counter at `up_loc_hist` increments on taken and decrements on not-taken, saturating at 0 and 7. `lk_loc_pred` is 1 when the counter at `lk_loc_idx` is 4 or more.
- R6: The arbiter counter selected by `lk_pc` drives `lk_use_global`: a value of 2 or more selects global, and a lower value selects local. `lk_taken` equals the vote of the selected component.
- R7: The arbiter counter at `up_pc` changes only when `up_glob_pred` differs from `up_loc_pred`. It moves up when the global vote matched `up_taken` and down otherwise, saturating at 0 and 3.
- R8: Both component counters are trained on every accepted update. Training uses the indices and votes carried on the update port, not the block's current histories.
- R9: A lookup in the same cycle as an update returns the state from before that update. The update is visible to lookups from the next cycle.
- R10: While `up_valid` is 0, no history or counter changes, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | CHS_IDX_W | Low address bits of the branch being looked up |
| lk_taken | output | 1 | Final predicted direction |
| lk_use_global | output | 1 | 1 when the global component was chosen |
| lk_glob_pred | output | 1 | Global component vote |
| lk_loc_pred | output | 1 | Local component vote |
| lk_glob_idx | output | GHIST_W | Global history used as the global table index |
| lk_loc_idx | output | LHIST_W | Per-branch history used as the local counter index |
| up_valid | input | 1 | Apply an update this cycle |
| up_pc | input | CHS_IDX_W | Low address bits of the resolved branch |
| up_taken | input | 1 | Actual outcome |
| up_glob_idx | input | GHIST_W | Global index captured at lookup |
| up_loc_hist | input | LHIST_W | Local index captured at lookup |
| up_glob_pred | input | 1 | Global vote captured at lookup |
| up_loc_pred | input | 1 | Local vote captured at lookup |

## Verification
Lookup and update share a cycle whenever a resolving branch trains the tables while fetch queries a branch. The hazard is sharpest when both use the same address, because one edge then rewrites the arbiter entry, the history entry and both counters that the lookup is reading. Every training step in the bench therefore presents the same address on both ports at once. The lookup outputs are sampled before the edge and must match the pre-update model, and the entry is checked again after the edge against the trained model. A separate phase feeds update indices that disagree with the current histories, which shows that training follows the carried indices rather than the live ones.

// File: rtl/tp_pkg.sv
package tp_pkg;

    // which component the arbiter hands the final answer to
    typedef enum logic {
        SRC_LOCAL  = 1'b0,
        SRC_GLOBAL = 1'b1
    } tp_src_e;

    // the two component votes travel together
    typedef struct packed {
        logic glob;
        logic loc;
    } tp_vote_t;

    // final direction from the votes and the arbiter's choice
    function automatic logic tp_pick(input tp_vote_t v, input tp_src_e s);
        return (s == SRC_GLOBAL) ? v.glob : v.loc;
    endfunction

    // arbiter trains only when the components disagree
    function automatic logic tp_arb_train(input tp_vote_t v);
        return v.glob ^ v.loc;
    endfunction

    // arbiter moves toward global when global was right
    function automatic logic tp_arb_toward_global(input tp_vote_t v, input logic outcome);
        return v.glob == outcome;
    endfunction

endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table #(
    parameter int IDX_W = 4,
    parameter int CTR_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_up
);
    localparam int             DEPTH   = 1 << IDX_W;
    localparam logic [CTR_W-1:0] CMAX    = {CTR_W{1'b1}};
    localparam logic [CTR_W-1:0] WEAK_NT = {1'b0, {(CTR_W-1){1'b1}}};
    localparam logic [CTR_W-1:0] ONE     = {{(CTR_W-1){1'b0}}, 1'b1};

    logic [CTR_W-1:0] ent [DEPTH];
    logic [CTR_W-1:0] wr_cur;
    logic [CTR_W-1:0] wr_nxt;

    // read side: taken when the counter sits in its upper half
    assign rd_taken = ent[rd_idx][CTR_W-1];

    // saturating step for the entry being trained
    assign wr_cur = ent[wr_idx];
    always_comb begin
        if (wr_up) begin
            wr_nxt = (wr_cur == CMAX) ? wr_cur : wr_cur + ONE;
        end else begin
            wr_nxt = (wr_cur == '0) ? wr_cur : wr_cur - ONE;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ent[i] <= WEAK_NT;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                ent[i] <= wr_nxt;
            end
        end
    end

endmodule

// File: rtl/tp_hist_table.sv
module tp_hist_table #(
    parameter int IDX_W = 3,
    parameter int W     = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [W-1:0]     rd_hist,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_bit
);
    localparam int DEPTH = 1 << IDX_W;

    logic [W-1:0] ent [DEPTH];
    logic [W-1:0] wr_nxt;

    assign rd_hist = ent[rd_idx];
    assign wr_nxt  = {ent[wr_idx][W-2:0], wr_bit};

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ent[i] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                ent[i] <= wr_nxt;
            end
        end
    end

endmodule

// File: rtl/tp_ghr.sv
module tp_ghr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         shift_in,
    output logic [W-1:0] hist
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= '0;
        end else if (shift_en) begin
            hist <= {hist[W-2:0], shift_in};
        end
    end
endmodule

// File: rtl/tourney_pred.sv
module tourney_pred
    import tp_pkg::*;
#(
    parameter int CHS_IDX_W = 10,
    parameter int GHIST_W   = 10,
    parameter int LHT_IDX_W = 8,
    parameter int LHIST_W   = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CHS_IDX_W-1:0] lk_pc,
    output logic                 lk_taken,
    output logic                 lk_use_global,
    output logic                 lk_glob_pred,
    output logic                 lk_loc_pred,
    output logic [GHIST_W-1:0]   lk_glob_idx,
    output logic [LHIST_W-1:0]   lk_loc_idx,
    input  logic                 up_valid,
    input  logic [CHS_IDX_W-1:0] up_pc,
    input  logic                 up_taken,
    input  logic [GHIST_W-1:0]   up_glob_idx,
    input  logic [LHIST_W-1:0]   up_loc_hist,
    input  logic                 up_glob_pred,
    input  logic                 up_loc_pred
);
    localparam int CTR2_W = 2;
    localparam int CTR3_W = 3;

    logic [GHIST_W-1:0] ghist;
    logic [LHIST_W-1:0] lhist;
    tp_vote_t           lk_vote;
    tp_vote_t           up_vote;
    logic               arb_msb;
    tp_src_e            lk_src;
    logic               arb_en;
    logic               arb_up;

    // global history register
    tp_ghr #(.W(GHIST_W)) u_ghr (
        .clk      (clk),
        .rst      (rst),
        .shift_en (up_valid),
        .shift_in (up_taken),
        .hist     (ghist)
    );

    // per-branch history words
    tp_hist_table #(.IDX_W(LHT_IDX_W), .W(LHIST_W)) u_lht (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (lk_pc[LHT_IDX_W-1:0]),
        .rd_hist (lhist),
        .wr_en   (up_valid),
        .wr_idx  (up_pc[LHT_IDX_W-1:0]),
        .wr_bit  (up_taken)
    );

    // global component: 2-bit counters indexed by global history
    tp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(CTR2_W)) u_gtab (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (ghist),
        .rd_taken (lk_vote.glob),
        .wr_en    (up_valid),
        .wr_idx   (up_glob_idx),
        .wr_up    (up_taken)
    );

    // local component: 3-bit counters indexed by per-branch history
    tp_ctr_table #(.IDX_W(LHIST_W), .CTR_W(CTR3_W)) u_ltab (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (lhist),
        .rd_taken (lk_vote.loc),
        .wr_en    (up_valid),
        .wr_idx   (up_loc_hist),
        .wr_up    (up_taken)
    );

    // arbiter training decision from the votes carried back
    assign up_vote.glob = up_glob_pred;
    assign up_vote.loc  = up_loc_pred;
    assign arb_en       = up_valid && tp_arb_train(up_vote);
    assign arb_up       = tp_arb_toward_global(up_vote, up_taken);

    // arbiter: 2-bit counters indexed by branch address
    tp_ctr_table #(.IDX_W(CHS_IDX_W), .CTR_W(CTR2_W)) u_arb (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (lk_pc),
        .rd_taken (arb_msb),
        .wr_en    (arb_en),
        .wr_idx   (up_pc),
        .wr_up    (arb_up)
    );

    assign lk_src        = tp_src_e'(arb_msb);
    assign lk_use_global = (lk_src == SRC_GLOBAL);
    assign lk_taken      = tp_pick(lk_vote, lk_src);
    assign lk_glob_pred  = lk_vote.glob;
    assign lk_loc_pred   = lk_vote.loc;
    assign lk_glob_idx   = ghist;
    assign lk_loc_idx    = lhist;

endmodule

// File: rtl/tourney_pred_chk.sv
module tourney_pred_chk #(
    parameter int CHS_IDX_W = 10,
    parameter int GHIST_W   = 10,
    parameter int LHIST_W   = 10
) (
    input logic                 clk,
    input logic                 rst,
    input logic [CHS_IDX_W-1:0] lk_pc,
    input logic                 lk_taken,
    input logic                 lk_use_global,
    input logic                 lk_glob_pred,
    input logic                 lk_loc_pred,
    input logic [GHIST_W-1:0]   lk_glob_idx,
    input logic [LHIST_W-1:0]   lk_loc_idx,
    input logic                 up_valid,
    input logic [CHS_IDX_W-1:0] up_pc,
    input logic                 up_taken,
    input logic                 up_glob_pred,
    input logic                 up_loc_pred
);
    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (lk_glob_idx == '0) && (lk_loc_idx == '0) && !lk_use_global
                       && !lk_glob_pred && !lk_loc_pred && !lk_taken); // R1

    AST_GHR_SHIFT: assert property (@(posedge clk) disable iff (rst)
        up_valid |=> lk_glob_idx == {$past(lk_glob_idx[GHIST_W-2:0]), $past(up_taken)}); // R2

    AST_IDLE_GHR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !up_valid |=> $stable(lk_glob_idx)); // R10

    AST_LHIST_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (up_valid && (up_pc == lk_pc)) |=>
            (!$stable(lk_pc) || (lk_loc_idx == {$past(lk_loc_idx[LHIST_W-2:0]), $past(up_taken)}))); // R4

    AST_ARB_AGREE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (up_valid && (up_pc == lk_pc) && (up_glob_pred == up_loc_pred)) |=>
            (!$stable(lk_pc) || $stable(lk_use_global))); // R7

    AST_ARB_KEEP_GLOBAL: assert property (@(posedge clk) disable iff (rst)
        (up_valid && (up_pc == lk_pc) && lk_use_global && (up_glob_pred != up_loc_pred)
         && (up_glob_pred == up_taken)) |=> (!$stable(lk_pc) || lk_use_global)); // R7

    AST_FINAL_FROM_CHOICE: assert property (@(posedge clk) disable iff (rst)
        (lk_glob_pred == lk_loc_pred) |-> (lk_taken == lk_glob_pred)); // R6

endmodule

bind tourney_pred tourney_pred_chk #(
    .CHS_IDX_W (CHS_IDX_W),
    .GHIST_W   (GHIST_W),
    .LHIST_W   (LHIST_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .lk_pc         (lk_pc),
    .lk_taken      (lk_taken),
    .lk_use_global (lk_use_global),
    .lk_glob_pred  (lk_glob_pred),
    .lk_loc_pred   (lk_loc_pred),
    .lk_glob_idx   (lk_glob_idx),
    .lk_loc_idx    (lk_loc_idx),
    .up_valid      (up_valid),
    .up_pc         (up_pc),
    .up_taken      (up_taken),
    .up_glob_pred  (up_glob_pred),
    .up_loc_pred   (up_loc_pred)
);

// File: tb/tourney_pred_test.sv
`timescale 1ns/1ps
module tourney_pred_test;
    localparam int PCW = 4;
    localparam int GW  = 4;
    localparam int LIW = 3;
    localparam int LW  = 4;
    localparam int NPC = 1 << PCW;
    localparam int NG  = 1 << GW;
    localparam int NLH = 1 << LIW;
    localparam int NL  = 1 << LW;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [PCW-1:0] lk_pc = '0;
    logic           lk_taken, lk_use_global, lk_glob_pred, lk_loc_pred;
    logic [GW-1:0]  lk_glob_idx;
    logic [LW-1:0]  lk_loc_idx;
    logic           up_valid = 1'b0;
    logic [PCW-1:0] up_pc = '0;
    logic           up_taken = 1'b0;
    logic [GW-1:0]  up_glob_idx = '0;
    logic [LW-1:0]  up_loc_hist = '0;
    logic           up_glob_pred = 1'b0;
    logic           up_loc_pred = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    tourney_pred #(.CHS_IDX_W(PCW), .GHIST_W(GW), .LHT_IDX_W(LIW), .LHIST_W(LW)) uut (
        .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(lk_taken),
        .lk_use_global(lk_use_global), .lk_glob_pred(lk_glob_pred),
        .lk_loc_pred(lk_loc_pred), .lk_glob_idx(lk_glob_idx), .lk_loc_idx(lk_loc_idx),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
        .up_glob_idx(up_glob_idx), .up_loc_hist(up_loc_hist),
        .up_glob_pred(up_glob_pred), .up_loc_pred(up_loc_pred)
    );

    // reference state derived from the requirements
    int gm [NG];
    int lm [NL];
    int cm [NPC];
    int lht [NLH];
    int ghr;
    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string tag, input string ph, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s (phase %s) actual=%0d expected=%0d", tag, ph, act, exp);
        end
    endtask

    function automatic int rnd();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return int'(lfsr);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NG; i++) gm[i] = 1;
        for (int i = 0; i < NL; i++) lm[i] = 3;
        for (int i = 0; i < NPC; i++) cm[i] = 1;
        for (int i = 0; i < NLH; i++) lht[i] = 0;
        ghr = 0;
    endtask

    task automatic model_update(input int pc, input int t, input int gi, input int lh, input int gp, input int lp);
        if (t != 0) begin
            if (gm[gi] < 3) gm[gi]++;
            if (lm[lh] < 7) lm[lh]++;
        end else begin
            if (gm[gi] > 0) gm[gi]--;
            if (lm[lh] > 0) lm[lh]--;
        end
        if (gp != lp) begin
            if (gp == t) begin
                if (cm[pc] < 3) cm[pc]++;
            end else begin
                if (cm[pc] > 0) cm[pc]--;
            end
        end
        lht[pc % NLH] = ((lht[pc % NLH] << 1) | t) % NL;
        ghr = ((ghr << 1) | t) % NG;
    endtask

    // compare lookup outputs for the current lk_pc against the model
    task automatic check_lookup(input int pc, input string ph);
        int eg, egp, elh, elp, eug, et;
        eg  = ghr;
        egp = (gm[eg] >= 2) ? 1 : 0;
        elh = lht[pc % NLH];
        elp = (lm[elh] >= 4) ? 1 : 0;
        eug = (cm[pc] >= 2) ? 1 : 0;
        et  = (eug != 0) ? egp : elp;
        chk(int'(lk_glob_idx) == eg, "R2 glob_idx", ph, int'(lk_glob_idx), eg);
        chk(int'(lk_glob_pred) == egp, "R3 glob_pred", ph, int'(lk_glob_pred), egp);
        chk(int'(lk_loc_idx) == elh, "R4 loc_idx", ph, int'(lk_loc_idx), elh);
        chk(int'(lk_loc_pred) == elp, "R5 loc_pred", ph, int'(lk_loc_pred), elp);
        chk(int'(lk_use_global) == eug, "R6 use_global", ph, int'(lk_use_global), eug);
        chk(int'(lk_taken) == et, "R6 taken", ph, int'(lk_taken), et);
    endtask

    task automatic sweep(input string ph);
        for (int p = 0; p < NPC; p++) begin
            lk_pc = PCW'(p);
            #1;
            check_lookup(p, ph);
        end
    endtask

    // same-address lookup and update in one cycle; indices come from the lookup
    task automatic step(input int pc, input int t, input string ph);
        int gi, lh, gp, lp;
        @(negedge clk);
        lk_pc = PCW'(pc);
        #1;
        check_lookup(pc, {"R9 pre/", ph});
        gi = int'(lk_glob_idx); lh = int'(lk_loc_idx);
        gp = int'(lk_glob_pred); lp = int'(lk_loc_pred);
        up_valid = 1'b1; up_pc = PCW'(pc); up_taken = t[0];
        up_glob_idx = GW'(gi); up_loc_hist = LW'(lh);
        up_glob_pred = gp[0]; up_loc_pred = lp[0];
        @(posedge clk);
        model_update(pc, t, gi, lh, gp, lp);
        @(negedge clk);
        up_valid = 1'b0;
        #1;
        check_lookup(pc, {"R9 post/", ph});
    endtask

    // update with indices and votes unrelated to the live state
    task automatic step_raw(input int pc, input int t, input int gi, input int lh, input int gp, input int lp);
        @(negedge clk);
        up_valid = 1'b1; up_pc = PCW'(pc); up_taken = t[0];
        up_glob_idx = GW'(gi); up_loc_hist = LW'(lh);
        up_glob_pred = gp[0]; up_loc_pred = lp[0];
        @(posedge clk);
        model_update(pc, t, gi, lh, gp, lp);
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        sweep("R1 reset");

        // saturation of the global and local counters on one branch
        for (int i = 0; i < 12; i++) step(5, 1, "R3 taken run");
        for (int i = 0; i < 12; i++) step(5, 0, "R5 not-taken run");
        sweep("R3 after runs");

        // alternating branch: the components disagree, the arbiter moves
        for (int i = 0; i < 40; i++) step(3, i % 2, "R7 alternate");
        for (int i = 0; i < 30; i++) step(9, (i % 3 == 0) ? 1 : 0, "R7 period3");
        sweep("R7 after");

        // mixed traffic over all addresses
        for (int i = 0; i < 300; i++) begin
            int r;
            r = rnd();
            step(r % NPC, ((r >> 5) % 4 != 0) ? 1 : 0, "R7 mixed");
        end
        sweep("R6 after mixed");

        // training follows the carried indices and votes
        for (int i = 0; i < 80; i++) begin
            int r;
            r = rnd();
            step_raw(r % NPC, (r >> 4) & 1, (r >> 5) % NG, (r >> 9) % NL, (r >> 13) & 1, (r >> 14) & 1);
        end
        sweep("R8 raw updates");

        // no valid: fields toggle, nothing may move
        for (int i = 0; i < 25; i++) begin
            int r;
            r = rnd();
            @(negedge clk);
            up_valid = 1'b0; up_pc = PCW'(r); up_taken = r[3];
            up_glob_idx = GW'(r >> 4); up_loc_hist = LW'(r >> 8);
            up_glob_pred = r[12]; up_loc_pred = r[13];
        end
        @(negedge clk);
        sweep("R10 idle");

        // reset again after training
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        sweep("R1 re-reset");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule